// File: doc/BRIEF.md
# Signed-Digit Quotient Accumulator

This block sits at the back end of an iterative divider. It turns a stream of radix-4 signed quotient digits into an ordinary two's-complement binary quotient. Each digit has a sign flag and a magnitude of 0, 1 or 2. Positive and negative magnitudes are kept in two separate shift registers, so no carry is ever resolved while digits arrive. A single subtraction, positive minus negative, is done only when the divider signals that it has finished.

The divider may deliver up to three digits in one cycle, on three lanes. Lane 0 holds the oldest digit. Every valid digit moves both registers two bit positions to the left. The earliest digit therefore ends up in the most significant position of the result. A clear input empties both registers before a new division starts. A finish strobe captures the difference and flags it as valid for one cycle.

Top module: `sd_quot_acc`

## Requirements
- R1: While reset is held, and after it is released, `quot_o` is zero and `quot_vld_o` is low. Both registers start empty, so a finish with no digits gives zero.
- R2: A valid digit with sign bit 0 shifts both registers left by 2. Its magnitude (lane bits `dig_mag_i[2i+1:2i]`) goes into the low two bits of the positive register, and zeros go into the negative register.
- R3: A valid digit with sign bit 1 shifts both registers left by 2. Its magnitude goes into the low two bits of the negative register, and zeros go into the positive register.
- R4: A digit of magnitude 0 adds nothing to the value, whether its sign is set or not. It still counts as one digit position, so earlier digits move up by a factor of 4.
- R5: The first digit received carries the highest weight. After n digits d1..dn the value is the sum of dk·4^(n−k), taken modulo 2^34.
- R6: Lanes are taken in the order lane 0, lane 1, lane 2 within a cycle. Lanes whose valid bit is low are skipped and do not shift. Each valid lane shifts by two bits.
- R7: When `fin_i` is high, `quot_o` on the next cycle equals positive minus negative modulo 2^34, counting digits given in that same cycle. `quot_vld_o` is high on exactly that cycle. Finish does not empty the registers.
- R8: Without `fin_i`, `quot_o` keeps its value and `quot_vld_o` is low on the next cycle.
- R9: `clr_i` empties both registers and takes priority over digits given in the same cycle. A finish in the same cycle as a clear reports zero.
- R10: Digits beyond the 17 that fit are allowed. The oldest bits fall off the top, and the result is the R5 sum modulo 2^34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty both digit registers |
| dig_vld_i | input | 3 | Per-lane digit valid, lane 0 oldest |
| dig_sgn_i | input | 3 | Per-lane sign, 1 = negative |
| dig_mag_i | input | 6 | Per-lane magnitude, 2 bits each (0 to 2) |
| fin_i | input | 1 | Capture the binary quotient |
| quot_o | output | 34 | Binary quotient, positive minus negative |
| quot_vld_o | output | 1 | One-cycle flag that `quot_o` was just updated |

## Verification
The conversion is checked with digits that are all positive, all negative and mixed in sign. All-positive and all-negative streams separate a wrong routing into the two registers from a wrong final subtraction. Mixed streams expose a wrong digit weight. Streams with +0 and −0 show whether a zero digit is weighted without adding value. Multi-lane cycles with gaps in the valid bits show whether lane order is wrong or an idle lane shifts by mistake. Overlong streams, clears that collide with digits or with finish, and a long random run against a modular reference model cover the edges of R9 and R10.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
    localparam int unsigned MAG_W   = 2;
    localparam int unsigned SHIFT_W = 2;
    localparam int unsigned MAG_MAX = 2;
endpackage

// File: rtl/sdq_lane_merge.sv
module sdq_lane_merge
    import sdq_pkg::*;
#(
    parameter int unsigned QW    = 34,
    parameter int unsigned LANES = 3
) (
    input  logic                   clr,
    input  logic [LANES-1:0]       vld,
    input  logic [LANES-1:0]       sgn,
    input  logic [LANES*MAG_W-1:0] mag,
    input  logic [QW-1:0]          pos_q,
    input  logic [QW-1:0]          neg_q,
    output logic [QW-1:0]          pos_n,
    output logic [QW-1:0]          neg_n
);
    localparam int unsigned KEEP_W = QW - SHIFT_W;

    logic [QW-1:0] pos_s [LANES+1];
    logic [QW-1:0] neg_s [LANES+1];

    assign pos_s[0] = pos_q;
    assign neg_s[0] = neg_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [MAG_W-1:0] m_pos;
        logic [MAG_W-1:0] m_neg;
        assign m_pos = sgn[i] ? '0 : mag[i*MAG_W +: MAG_W];
        assign m_neg = sgn[i] ? mag[i*MAG_W +: MAG_W] : '0;
        assign pos_s[i+1] = vld[i] ? {pos_s[i][KEEP_W-1:0], m_pos} : pos_s[i];
        assign neg_s[i+1] = vld[i] ? {neg_s[i][KEEP_W-1:0], m_neg} : neg_s[i];
    end

    assign pos_n = clr ? '0 : pos_s[LANES];
    assign neg_n = clr ? '0 : neg_s[LANES];
endmodule

// File: rtl/sdq_final_sub.sv
module sdq_final_sub #(
    parameter int unsigned W = 34
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff
);
    assign diff = minuend + (~subtrahend) + W'(1);
endmodule

// File: rtl/sd_quot_acc.sv
module sd_quot_acc
    import sdq_pkg::*;
#(
    parameter int unsigned QW    = 34,
    parameter int unsigned LANES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic [LANES-1:0]       dig_vld_i,
    input  logic [LANES-1:0]       dig_sgn_i,
    input  logic [LANES*MAG_W-1:0] dig_mag_i,
    input  logic                   fin_i,
    output logic [QW-1:0]          quot_o,
    output logic                   quot_vld_o
);
    typedef struct packed {
        logic [QW-1:0] pos;
        logic [QW-1:0] neg;
        logic [QW-1:0] quot;
        logic          vld;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [QW-1:0] pos_nx, neg_nx, diff;

    sdq_lane_merge #(.QW(QW), .LANES(LANES)) u_merge (
        .clr   (clr_i),
        .vld   (dig_vld_i),
        .sgn   (dig_sgn_i),
        .mag   (dig_mag_i),
        .pos_q (st_q.pos),
        .neg_q (st_q.neg),
        .pos_n (pos_nx),
        .neg_n (neg_nx)
    );

    sdq_final_sub #(.W(QW)) u_sub (
        .minuend    (pos_nx),
        .subtrahend (neg_nx),
        .diff       (diff)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pos = pos_nx;
        st_d.neg = neg_nx;
        st_d.vld = fin_i;
        if (fin_i) begin
            st_d.quot = diff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quot_o     = st_q.quot;
    assign quot_vld_o = st_q.vld;

    // R7
    fin_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> quot_vld_o);

    // R8
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> !quot_vld_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(quot_o));

    // R9
    clear_finish_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && fin_i) |=> (quot_o == '0));

    for (genvar i = 0; i < LANES; i++) begin : g_mag_chk
        // R4
        legal_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dig_vld_i[i] |-> (dig_mag_i[i*MAG_W +: MAG_W] <= MAG_W'(MAG_MAX)));
    end
endmodule

// File: tb/sim_sd_quot_acc.sv
module sim_sd_quot_acc;
    localparam int QW = 34;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic [2:0]    dig_vld_i = '0;
    logic [2:0]    dig_sgn_i = '0;
    logic [5:0]    dig_mag_i = '0;
    logic          fin_i = 1'b0;
    logic [QW-1:0] quot_o;
    logic          quot_vld_o;

    sd_quot_acc u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .dig_vld_i(dig_vld_i),
        .dig_sgn_i(dig_sgn_i), .dig_mag_i(dig_mag_i), .fin_i(fin_i),
        .quot_o(quot_o), .quot_vld_o(quot_vld_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [QW-1:0] exp;
        string         req;
    } exp_t;

    exp_t          sb_q[$];
    int            n_chk = 0;
    int            n_bad = 0;
    logic [QW-1:0] model = '0;
    bit            done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [QW-1:0] act,
                         input logic [QW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle; model is updated from the requirements
    task automatic step(input logic [2:0] v, input logic [2:0] s, input logic [5:0] m,
                        input logic clr, input logic fin, input string req);
        exp_t e;
        @(negedge clk);
        dig_vld_i = v; dig_sgn_i = s; dig_mag_i = m; clr_i = clr; fin_i = fin;
        if (clr) model = '0;
        else begin
            for (int i = 0; i < 3; i++) begin
                if (v[i]) begin
                    logic [QW-1:0] mg;
                    mg = QW'(m[i*2 +: 2]);
                    model = (model << 2) + (s[i] ? (~mg + QW'(1)) : mg);
                end
            end
        end
        if (fin) begin
            e.exp = model; e.req = req;
            sb_q.push_back(e);
        end
    endtask

    task automatic idle();
        step(3'b000, 3'b000, 6'd0, 1'b0, 1'b0, "idle");
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && quot_vld_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected valid", quot_o, '0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(quot_o == e.exp, e.req, quot_o, e.exp);
            end
        end
    end

    task automatic finish_run();
        check(sb_q.size() == 0, "R7 missing valid", QW'(sb_q.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            check(1'b0, "watchdog", '0, '0);
            finish_run();
        end
    end

    initial begin
        logic [QW-1:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(quot_o == '0 && !quot_vld_o, "R1 in reset", quot_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(quot_o == '0 && !quot_vld_o, "R1 after reset", quot_o, '0);
        step(3'b000, 3'b000, 6'd0, 1'b0, 1'b1, "R1 empty finish");
        idle();

        // R2 positive digits only: +2,+1 -> 9
        step(3'b001, 3'b000, 6'd2, 1'b1, 1'b0, "clr");
        step(3'b001, 3'b000, 6'd2, 1'b0, 1'b0, "R2");
        step(3'b001, 3'b000, 6'd1, 1'b0, 1'b1, "R2 positive stream");
        // R3 negative digits: clear then -1,-2 -> -6
        step(3'b000, 3'b000, 6'd0, 1'b1, 1'b0, "clr");
        step(3'b001, 3'b001, 6'd1, 1'b0, 1'b0, "R3");
        step(3'b001, 3'b001, 6'd2, 1'b0, 1'b1, "R3 negative stream");
        // R5 mixed weight: +2,-1,+1 -> 29
        step(3'b000, 3'b000, 6'd0, 1'b1, 1'b0, "clr");
        step(3'b001, 3'b000, 6'd2, 1'b0, 1'b0, "R5");
        step(3'b001, 3'b001, 6'd1, 1'b0, 1'b0, "R5");
        step(3'b001, 3'b000, 6'd1, 1'b0, 1'b1, "R5 mixed weight");
        // R4 signed zero: +1,-0,+0 -> 16
        step(3'b000, 3'b000, 6'd0, 1'b1, 1'b0, "clr");
        step(3'b001, 3'b000, 6'd1, 1'b0, 1'b0, "R4");
        step(3'b001, 3'b001, 6'd0, 1'b0, 1'b0, "R4");
        step(3'b001, 3'b000, 6'd0, 1'b0, 1'b1, "R4 signed zero weight");
        step(3'b001, 3'b001, 6'd0, 1'b1, 1'b0, "clr");
        step(3'b001, 3'b001, 6'd0, 1'b0, 1'b1, "R4 minus zero alone");
        // R6 three lanes: +1,-2,+2 -> 10
        step(3'b000, 3'b000, 6'd0, 1'b1, 1'b0, "clr");
        step(3'b111, 3'b010, {2'd2, 2'd2, 2'd1}, 1'b0, 1'b1, "R6 three lanes");
        // R6 gap lane: lane0 +2, lane1 idle, lane2 -1 -> 7
        step(3'b000, 3'b000, 6'd0, 1'b1, 1'b0, "clr");
        step(3'b101, 3'b100, {2'd1, 2'd2, 2'd2}, 1'b0, 1'b1, "R6 skipped lane");
        // R7 finish keeps registers: add +1 -> 29
        step(3'b001, 3'b000, 6'd1, 1'b0, 1'b1, "R7 finish keeps state");
        // R8 hold without finish
        idle();
        held = quot_o;
        step(3'b011, 3'b001, 6'd6, 1'b0, 1'b0, "R8");
        @(negedge clk);
        check(quot_o == held && !quot_vld_o, "R8 hold", quot_o, held);
        // R9 clear beats digits, then finish
        step(3'b111, 3'b000, 6'd42, 1'b1, 1'b0, "R9");
        step(3'b000, 3'b000, 6'd0, 1'b0, 1'b1, "R9 clear beats digits");
        step(3'b001, 3'b000, 6'd2, 1'b0, 1'b0, "R9");
        step(3'b111, 3'b000, 6'd42, 1'b1, 1'b1, "R9 clear with finish");
        // R10 overlong stream: 20 digits of +1
        for (int k = 0; k < 20; k++) step(3'b001, 3'b000, 6'd1, 1'b0, 1'b0, "R10");
        step(3'b000, 3'b000, 6'd0, 1'b0, 1'b1, "R10 overflow modulo");
        step(3'b000, 3'b000, 6'd0, 1'b1, 1'b0, "clr");
        for (int k = 0; k < 19; k++) step(3'b001, 3'b001, 6'd2, 1'b0, 1'b0, "R10");
        step(3'b000, 3'b000, 6'd0, 1'b0, 1'b1, "R10 negative overflow");
        // random run
        for (int k = 0; k < 400; k++) begin
            logic [2:0] v, s;
            logic [5:0] m;
            v = 3'($urandom);
            s = 3'($urandom);
            for (int i = 0; i < 3; i++) m[i*2 +: 2] = 2'($urandom_range(0, 2));
            step(v, s, m, ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) == 0),
                 "R5 R6 random");
        end
        idle();
        idle();
        finish_run();
    end
endmodule